// File: doc/BRIEF.md
# Translation Unit Control and Fault Register Block

This block is the software-facing register file of an address translation unit. Through a single-cycle register bus, software switches the unit between off, running and held. It programs the page-table base, a configuration word and a set of prefetch windows, and issues flush commands. The block turns those commands into steering signals and one-cycle pulses for the translation datapath, which lives outside this block.

In the other direction the datapath reports faults as a valid strobe, a 3-bit type code and the faulting address. The block records each fault as a sticky interrupt bit and copies the address into one of four capture registers chosen by the fault's class. If translation is running, the block also pulls the unit into the held state. The unit stays held until software writes the run code again. An interrupt line is high while any fault bit is pending. A held unit reports itself as drained once the datapath signals that nothing is in flight.

Top module: `xlat_ctl_regs`

## Requirements
- R1: After reset the unit is off (`xl_enable_o`=0, `xl_hold_o`=0). Every readable register reads 0 except the version register, `irq_o` is 0 and no flush pulse is active.
- R2: The control register at offset 0x00 accepts three codes. 0x0 selects off, 0x5 selects running (`xl_enable_o`=1, `xl_hold_o`=0) and 0x7 selects held (`xl_enable_o`=1, `xl_hold_o`=1). Any other value leaves the mode unchanged. Reading offset 0x00 returns the code of the current mode.
- R3: Bit 0 of the status register at offset 0x08 reads 1 exactly when the mode is held and `xl_idle_i` is 1. Its other bits read 0.
- R4: A fault strobe sets bit `flt_type_i` of the interrupt status register at offset 0x18. The type codes are: 0 page fault, 1 read multi-hit, 2 write multi-hit, 3 bus error, 4 read security, 5 read access, 6 write security, 7 write access. Bits 31:8 read 0.
- R5: The fault address is captured by class. Type 0 goes to offset 0x24. Types 2, 6 and 7 go to offset 0x28. Types 1, 4 and 5 go to offset 0x2C. Type 3 goes to offset 0x30. The other capture registers keep their values.
- R6: A fault arriving while the mode is running or held forces the held mode (control reads 0x7). This takes priority over a control write in the same cycle, and the mode stays held until a later write of 0x5. A fault while off is logged but leaves the mode off.
- R7: Writing offset 0x1C clears every interrupt status bit whose data bit is 1. A fault setting a bit in the same cycle as its clear leaves that bit set. Offset 0x1C reads 0.
- R8: `irq_o` is 1 exactly when at least one interrupt status bit is set.
- R9: A write to offset 0x0C with data bit 0 set gives a one-cycle `flush_all_o` pulse in the cycle after the write. A write to offset 0x10 with bit 0 set gives a one-cycle `flush_entry_o` pulse, with `flush_page_o` equal to data bits 31:12 of that write. A write to either offset with bit 0 clear gives no pulse.
- R10: The configuration (0x04), page-table base (0x14) and prefetch window registers (start/end pairs at 0x4C/0x50 and 0x54/0x58, continuing every 8 bytes) read back the last value written. The page-table base drives `pt_base_o`, and the windows drive `pf_win_o` with slot k at bits 32k+31:32k.
- R11: Offset 0x34 reads the parameter `VER_MAJOR` in bits 31:28 and 0 elsewhere.
- R12: Unmapped offsets read 0 and writes to them change nothing. Writes to the status, capture and version registers change nothing. `bus_rdata_o` is 0 when no read is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel_i | input | 1 | Register access this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, same cycle |
| xl_idle_i | input | 1 | Datapath has no transaction in flight |
| flt_valid_i | input | 1 | Fault report strobe |
| flt_type_i | input | 3 | Fault type code |
| flt_addr_i | input | 32 | Faulting address |
| xl_enable_o | output | 1 | Translation on |
| xl_hold_o | output | 1 | New traffic held |
| pt_base_o | output | 32 | Page-table base |
| cfg_o | output | 32 | Configuration word |
| pf_win_o | output | 128 | Prefetch window bounds |
| flush_all_o | output | 1 | Flush-everything pulse |
| flush_entry_o | output | 1 | Flush-one-page pulse |
| flush_page_o | output | 20 | Page number for the entry flush |
| irq_o | output | 1 | Fault interrupt |

## Verification
The hardest situations to reach are the same-cycle collisions. One is a fault strobe landing in the cycle where software rewrites the control register. The other is a fault landing in the cycle where software clears that same interrupt bit. Only one order can be correct for each collision, and neither happens unless fault and bus stimulus are lined up on one edge. The bench drives both in a single cycle for these cases. It also walks all eight fault types with distinct addresses, re-arming the unit between faults, so that every capture register and the auto-hold path are seen.

// File: rtl/xu_regs_pkg.sv
package xu_regs_pkg;
  localparam int unsigned XU_DW   = 32;
  localparam int unsigned XU_AW   = 8;
  localparam int unsigned XU_NFLT = 8;
  localparam int unsigned XU_FTW  = $clog2(XU_NFLT);

  typedef enum logic [1:0] {MODE_OFF, MODE_RUN, MODE_HOLD} xu_mode_e;

  localparam logic [XU_DW-1:0] CODE_OFF  = 32'h0;
  localparam logic [XU_DW-1:0] CODE_RUN  = 32'h5;
  localparam logic [XU_DW-1:0] CODE_HOLD = 32'h7;

  localparam logic [XU_AW-1:0] OFS_CTRL    = 8'h00;
  localparam logic [XU_AW-1:0] OFS_CFG     = 8'h04;
  localparam logic [XU_AW-1:0] OFS_STATUS  = 8'h08;
  localparam logic [XU_AW-1:0] OFS_FLALL   = 8'h0C;
  localparam logic [XU_AW-1:0] OFS_FLENT   = 8'h10;
  localparam logic [XU_AW-1:0] OFS_PTBASE  = 8'h14;
  localparam logic [XU_AW-1:0] OFS_INTSTAT = 8'h18;
  localparam logic [XU_AW-1:0] OFS_INTCLR  = 8'h1C;
  localparam logic [XU_AW-1:0] OFS_CAP0    = 8'h24;
  localparam logic [XU_AW-1:0] OFS_VERSION = 8'h34;
  localparam logic [XU_AW-1:0] OFS_SLOT0   = 8'h4C;

  // capture class: capture register offset = OFS_CAP0 + 4*class
  localparam logic [1:0] DST_PAGE = 2'd0;
  localparam logic [1:0] DST_WR   = 2'd1;
  localparam logic [1:0] DST_RD   = 2'd2;
  localparam logic [1:0] DST_BUS  = 2'd3;

  function automatic logic [1:0] fault_dest(input logic [XU_FTW-1:0] t);
    case (t)
      3'd0:                fault_dest = DST_PAGE;
      3'd3:                fault_dest = DST_BUS;
      3'd1, 3'd4, 3'd5:    fault_dest = DST_RD;
      default:             fault_dest = DST_WR;
    endcase
  endfunction

  function automatic logic [XU_DW-1:0] mode_code(input xu_mode_e m);
    case (m)
      MODE_RUN:  mode_code = CODE_RUN;
      MODE_HOLD: mode_code = CODE_HOLD;
      default:   mode_code = CODE_OFF;
    endcase
  endfunction

  function automatic logic [XU_AW-1:0] cap_ofs(input int unsigned k);
    cap_ofs = XU_AW'(32'(OFS_CAP0) + 4 * k);
  endfunction

  function automatic logic [XU_AW-1:0] slot_ofs(input int unsigned k);
    slot_ofs = XU_AW'(32'(OFS_SLOT0) + 4 * k);
  endfunction
endpackage

// File: rtl/xu_mode_ctl.sv
module xu_mode_ctl
  import xu_regs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr_i,
  input  logic [XU_DW-1:0] ctrl_wdata_i,
  input  logic             fault_evt_i,
  input  logic             idle_i,
  output xu_mode_e         mode_o,
  output logic             drained_o
);
  xu_mode_e mode_q;
  logic     code_ok;
  logic     fault_hold;

  assign code_ok    = (ctrl_wdata_i == CODE_OFF) || (ctrl_wdata_i == CODE_RUN) ||
                      (ctrl_wdata_i == CODE_HOLD);
  assign fault_hold = fault_evt_i && (mode_q != MODE_OFF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_OFF;
    end else if (fault_hold) begin
      mode_q <= MODE_HOLD;
    end else if (ctrl_wr_i && code_ok) begin
      case (ctrl_wdata_i)
        CODE_RUN:  mode_q <= MODE_RUN;
        CODE_HOLD: mode_q <= MODE_HOLD;
        default:   mode_q <= MODE_OFF;
      endcase
    end
  end

  assign mode_o    = mode_q;
  assign drained_o = (mode_q == MODE_HOLD) && idle_i;

  assert_fault_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_evt_i && mode_q != MODE_OFF) |=> (mode_q == MODE_HOLD));
  assert_off_fault_stays_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_evt_i && mode_q == MODE_OFF && !ctrl_wr_i) |=> (mode_q == MODE_OFF));
  assert_run_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr_i && ctrl_wdata_i == CODE_RUN && !fault_evt_i) |=> (mode_q == MODE_RUN));
  assert_bad_code_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr_i && !code_ok && !fault_evt_i) |=> $stable(mode_q));
endmodule

// File: rtl/xu_fault_log.sv
module xu_fault_log
  import xu_regs_pkg::*;
#(
  parameter int unsigned NUM_FLT = XU_NFLT
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flt_valid_i,
  input  logic [XU_FTW-1:0]       flt_type_i,
  input  logic [XU_DW-1:0]        flt_addr_i,
  input  logic                    clr_wr_i,
  input  logic [NUM_FLT-1:0]      clr_bits_i,
  output logic [NUM_FLT-1:0]      status_o,
  output logic [3:0][XU_DW-1:0]   cap_o,
  output logic                    irq_o
);
  logic [NUM_FLT-1:0]    status_q;
  logic [3:0][XU_DW-1:0] cap_q;
  logic [NUM_FLT-1:0]    set_mask;
  logic [NUM_FLT-1:0]    clr_mask;
  logic [1:0]            dest;

  assign set_mask = flt_valid_i ? (NUM_FLT'(1) << flt_type_i) : '0;
  assign clr_mask = clr_wr_i ? clr_bits_i : '0;
  assign dest     = fault_dest(flt_type_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      cap_q    <= '0;
    end else begin
      status_q <= (status_q & ~clr_mask) | set_mask;
      if (flt_valid_i) cap_q[dest] <= flt_addr_i;
    end
  end

  assign status_o = status_q;
  assign cap_o    = cap_q;
  assign irq_o    = |status_q;

  assert_set_sticks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid_i |=> ((status_q & $past(set_mask)) == $past(set_mask)));
  assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr_i |=> ((status_q & $past(clr_mask & ~set_mask)) == '0));
  assert_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid_i |=> (cap_q[$past(dest)] == $past(flt_addr_i)));
  assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(flt_valid_i));
endmodule

// File: rtl/xu_flush_gen.sv
module xu_flush_gen #(
  parameter int unsigned DW         = 32,
  parameter int unsigned PAGE_SHIFT = 12,
  localparam int unsigned PW        = DW - PAGE_SHIFT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          all_cmd_i,
  input  logic          ent_cmd_i,
  input  logic [PW-1:0] ent_page_i,
  output logic          all_pulse_o,
  output logic          ent_pulse_o,
  output logic [PW-1:0] ent_page_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      all_pulse_o <= 1'b0;
      ent_pulse_o <= 1'b0;
      ent_page_o  <= '0;
    end else begin
      all_pulse_o <= all_cmd_i;
      ent_pulse_o <= ent_cmd_i;
      if (ent_cmd_i) ent_page_o <= ent_page_i;
    end
  end

  assert_all_pulse_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    all_pulse_o |-> $past(all_cmd_i));
  assert_ent_page_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ent_cmd_i |=> (ent_pulse_o && ent_page_o == $past(ent_page_i)));
endmodule

// File: rtl/xu_cfg_bank.sv
module xu_cfg_bank
  import xu_regs_pkg::*;
#(
  parameter int unsigned NUM_PF_WIN = 2,
  localparam int unsigned NSLOT     = 2 * NUM_PF_WIN
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en_i,
  input  logic [XU_AW-1:0]       wr_addr_i,
  input  logic [XU_DW-1:0]       wdata_i,
  output logic [XU_DW-1:0]       cfg_o,
  output logic [XU_DW-1:0]       ptbase_o,
  output logic [NSLOT*XU_DW-1:0] slots_o
);
  logic [XU_DW-1:0] cfg_q;
  logic [XU_DW-1:0] ptbase_q;
  logic [XU_DW-1:0] slot_q [NSLOT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      ptbase_q <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == OFS_CFG)    cfg_q    <= wdata_i;
      if (wr_addr_i == OFS_PTBASE) ptbase_q <= wdata_i;
    end
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                                       slot_q[g] <= '0;
      else if (wr_en_i && wr_addr_i == slot_ofs(g))     slot_q[g] <= wdata_i;
    end
    assign slots_o[g*XU_DW +: XU_DW] = slot_q[g];
  end

  assign cfg_o    = cfg_q;
  assign ptbase_o = ptbase_q;

  assert_ptbase_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i == OFS_PTBASE) |=> (ptbase_q == $past(wdata_i)));
endmodule

// File: rtl/xlat_ctl_regs.sv
module xlat_ctl_regs
  import xu_regs_pkg::*;
#(
  parameter int unsigned NUM_PF_WIN = 2,
  parameter int unsigned PAGE_SHIFT = 12,
  parameter int unsigned VER_MAJOR  = 3,
  localparam int unsigned NSLOT     = 2 * NUM_PF_WIN,
  localparam int unsigned PW        = XU_DW - PAGE_SHIFT
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_sel_i,
  input  logic                   bus_wr_i,
  input  logic [XU_AW-1:0]       bus_addr_i,
  input  logic [XU_DW-1:0]       bus_wdata_i,
  output logic [XU_DW-1:0]       bus_rdata_o,
  input  logic                   xl_idle_i,
  input  logic                   flt_valid_i,
  input  logic [XU_FTW-1:0]      flt_type_i,
  input  logic [XU_DW-1:0]       flt_addr_i,
  output logic                   xl_enable_o,
  output logic                   xl_hold_o,
  output logic [XU_DW-1:0]       pt_base_o,
  output logic [XU_DW-1:0]       cfg_o,
  output logic [NSLOT*XU_DW-1:0] pf_win_o,
  output logic                   flush_all_o,
  output logic                   flush_entry_o,
  output logic [PW-1:0]          flush_page_o,
  output logic                   irq_o
);
  logic                  wr_en, rd_en;
  logic                  ctrl_wr, clr_wr, all_cmd, ent_cmd;
  xu_mode_e              mode;
  logic                  drained;
  logic [XU_NFLT-1:0]    int_status;
  logic [3:0][XU_DW-1:0] cap;
  logic [XU_DW-1:0]      rd_val;

  assign wr_en   = bus_sel_i && bus_wr_i;
  assign rd_en   = bus_sel_i && !bus_wr_i;
  assign ctrl_wr = wr_en && (bus_addr_i == OFS_CTRL);
  assign clr_wr  = wr_en && (bus_addr_i == OFS_INTCLR);
  assign all_cmd = wr_en && (bus_addr_i == OFS_FLALL) && bus_wdata_i[0];
  assign ent_cmd = wr_en && (bus_addr_i == OFS_FLENT) && bus_wdata_i[0];

  xu_mode_ctl u_mode (
    .clk(clk), .rst_n(rst_n),
    .ctrl_wr_i(ctrl_wr), .ctrl_wdata_i(bus_wdata_i),
    .fault_evt_i(flt_valid_i), .idle_i(xl_idle_i),
    .mode_o(mode), .drained_o(drained)
  );

  xu_fault_log #(.NUM_FLT(XU_NFLT)) u_flt (
    .clk(clk), .rst_n(rst_n),
    .flt_valid_i(flt_valid_i), .flt_type_i(flt_type_i), .flt_addr_i(flt_addr_i),
    .clr_wr_i(clr_wr), .clr_bits_i(bus_wdata_i[XU_NFLT-1:0]),
    .status_o(int_status), .cap_o(cap), .irq_o(irq_o)
  );

  xu_flush_gen #(.DW(XU_DW), .PAGE_SHIFT(PAGE_SHIFT)) u_flush (
    .clk(clk), .rst_n(rst_n),
    .all_cmd_i(all_cmd), .ent_cmd_i(ent_cmd),
    .ent_page_i(bus_wdata_i[XU_DW-1:PAGE_SHIFT]),
    .all_pulse_o(flush_all_o), .ent_pulse_o(flush_entry_o), .ent_page_o(flush_page_o)
  );

  xu_cfg_bank #(.NUM_PF_WIN(NUM_PF_WIN)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(wr_en), .wr_addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .cfg_o(cfg_o), .ptbase_o(pt_base_o), .slots_o(pf_win_o)
  );

  assign xl_enable_o = (mode != MODE_OFF);
  assign xl_hold_o   = (mode == MODE_HOLD);

  always_comb begin
    rd_val = '0;
    case (bus_addr_i)
      OFS_CTRL:    rd_val = mode_code(mode);
      OFS_CFG:     rd_val = cfg_o;
      OFS_STATUS:  rd_val = {{(XU_DW-1){1'b0}}, drained};
      OFS_PTBASE:  rd_val = pt_base_o;
      OFS_INTSTAT: rd_val = XU_DW'(int_status);
      OFS_VERSION: rd_val = {4'(VER_MAJOR), {(XU_DW-4){1'b0}}};
      default:     rd_val = '0;
    endcase
    for (int k = 0; k < 4; k++)
      if (bus_addr_i == cap_ofs(k)) rd_val = cap[k];
    for (int k = 0; k < NSLOT; k++)
      if (bus_addr_i == slot_ofs(k)) rd_val = pf_win_o[k*XU_DW +: XU_DW];
    bus_rdata_o = rd_en ? rd_val : '0;
  end

  assert_drained_needs_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && bus_addr_i == OFS_STATUS && bus_rdata_o[0]) |-> (xl_hold_o && xl_idle_i));
  assert_idle_bus_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (bus_rdata_o == '0));
endmodule

// File: tb/xlat_ctl_regs_tb_top.sv
`timescale 1ns/100ps
module xlat_ctl_regs_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_sel = 0, bus_wr = 0;
  logic [7:0]   bus_addr = 0;
  logic [31:0]  bus_wdata = 0;
  logic [31:0]  bus_rdata;
  logic         xl_idle = 0;
  logic         flt_valid = 0;
  logic [2:0]   flt_type = 0;
  logic [31:0]  flt_addr = 0;
  logic         xl_enable, xl_hold, flush_all, flush_entry, irq;
  logic [31:0]  pt_base, cfg;
  logic [127:0] pf_win;
  logic [19:0]  flush_page;

  always #2 clk = ~clk;

  xlat_ctl_regs dut_i (
    .clk(clk), .rst_n(rst_n),
    .bus_sel_i(bus_sel), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .xl_idle_i(xl_idle), .flt_valid_i(flt_valid), .flt_type_i(flt_type),
    .flt_addr_i(flt_addr),
    .xl_enable_o(xl_enable), .xl_hold_o(xl_hold), .pt_base_o(pt_base),
    .cfg_o(cfg), .pf_win_o(pf_win), .flush_all_o(flush_all),
    .flush_entry_o(flush_entry), .flush_page_o(flush_page), .irq_o(irq)
  );

  typedef struct {int kind; logic [31:0] exp; string req;} item_t;
  item_t q[$];
  event  mon_ev;
  int    checks = 0, failures = 0;
  bit    done = 0;

  // kinds: 0 rdata, 1 enable, 2 hold, 3 irq, 4 flush_all, 5 flush_entry, 6 page, 7 pt_base, 8 pf_win slot1
  function automatic logic [31:0] observe(int kind);
    case (kind)
      0: return bus_rdata;
      1: return 32'(xl_enable);
      2: return 32'(xl_hold);
      3: return 32'(irq);
      4: return 32'(flush_all);
      5: return 32'(flush_entry);
      6: return 32'(flush_page);
      7: return pt_base;
      default: return pf_win[63:32];
    endcase
  endfunction

  always begin
    @(mon_ev);
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      act = observe(it.kind);
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic expect_now(int kind, logic [31:0] exp, string req);
    item_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    q.push_back(it);
    -> mon_ev;
  endtask

  task automatic obs(int kind, logic [31:0] exp, string req);
    #0.5 expect_now(kind, exp, req);
    #0.1;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string req);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    #0.5 expect_now(0, exp, req);
    #0.5 bus_sel = 0;
  endtask

  task automatic fault(logic [2:0] t, logic [31:0] a);
    @(negedge clk); flt_valid = 1; flt_type = t; flt_addr = a;
    @(negedge clk); flt_valid = 0;
  endtask

  function automatic logic [7:0] exp_cap_ofs(logic [2:0] t);
    case (t)
      3'd0: return 8'h24;
      3'd3: return 8'h30;
      3'd1, 3'd4, 3'd5: return 8'h2C;
      default: return 8'h28;
    endcase
  endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] cap_exp [4];
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    obs(1, 0, "R1 enable"); obs(2, 0, "R1 hold"); obs(3, 0, "R1 irq");
    obs(4, 0, "R1 flush_all");
    rd(8'h00, 0, "R1 ctrl"); rd(8'h18, 0, "R1 intstat"); rd(8'h14, 0, "R1 ptbase");
    rd(8'h28, 0, "R1 cap"); rd(8'h08, 0, "R1 status");
    obs(0, 0, "R12 no read selected");

    // R2 control codes
    wr(8'h00, 32'h5);
    obs(1, 1, "R2 run enable"); obs(2, 0, "R2 run hold");
    rd(8'h00, 32'h5, "R2 ctrl run");
    wr(8'h00, 32'h3);
    rd(8'h00, 32'h5, "R2 bad code ignored");
    wr(8'h00, 32'h7);
    obs(1, 1, "R2 hold enable"); obs(2, 1, "R2 hold");
    // R3 drained status
    rd(8'h08, 0, "R3 held but busy");
    xl_idle = 1;
    rd(8'h08, 1, "R3 held and idle");
    wr(8'h00, 32'h5);
    rd(8'h08, 0, "R3 running and idle");

    // R4 R5 R6 R8: walk every fault type
    for (int t = 0; t < 8; t++) begin
      logic [31:0] a;
      a = 32'h1000_0000 + 32'(t) * 32'h0011_1111;
      fault(3'(t), a);
      cap_exp[(exp_cap_ofs(3'(t)) - 8'h24) >> 2] = a;
      obs(2, 1, "R6 fault holds");
      obs(3, 1, "R8 irq on fault");
      rd(8'h00, 32'h7, "R6 ctrl reads hold");
      rd(8'h18, (32'h1 << (t + 1)) - 1, "R4 status bits");
      rd(exp_cap_ofs(3'(t)), a, "R5 capture");
      rd(8'h00, 32'h7, "R6 still held");
      wr(8'h00, 32'h5);
      obs(2, 0, "R6 rearm");
    end
    for (int k = 0; k < 4; k++)
      rd(8'(8'h24 + 4 * k), cap_exp[k], "R5 capture kept");

    // R7 W1C
    wr(8'h1C, 32'h0F);
    rd(8'h18, 32'hF0, "R7 partial clear");
    obs(3, 1, "R8 irq still set");
    rd(8'h1C, 0, "R7 clear reads zero");
    wr(8'h1C, 32'hF0);
    rd(8'h18, 0, "R7 full clear");
    obs(3, 0, "R8 irq low");
    wr(8'h00, 32'h5);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = 8'h1C; bus_wdata = 32'h04;
    flt_valid = 1; flt_type = 3'd2; flt_addr = 32'hCAFE_0000;
    @(negedge clk); bus_sel = 0; bus_wr = 0; flt_valid = 0;
    rd(8'h18, 32'h04, "R7 set wins over clear");
    wr(8'h1C, 32'hFF);

    // R6 fault beats control write
    wr(8'h00, 32'h5);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = 8'h00; bus_wdata = 32'h5;
    flt_valid = 1; flt_type = 3'd0; flt_addr = 32'h0000_BEEF;
    @(negedge clk); bus_sel = 0; bus_wr = 0; flt_valid = 0;
    rd(8'h00, 32'h7, "R6 fault beats ctrl write");
    rd(8'h24, 32'h0000_BEEF, "R5 page capture");

    // R6 fault while off
    wr(8'h1C, 32'hFF);
    wr(8'h00, 32'h0);
    obs(1, 0, "R2 off");
    fault(3'd3, 32'h3333_0000);
    rd(8'h00, 32'h0, "R6 off stays off");
    rd(8'h18, 32'h08, "R4 logged while off");
    rd(8'h30, 32'h3333_0000, "R5 bus error capture");

    // R9 flushes
    wr(8'h0C, 32'h1);
    obs(4, 1, "R9 flush_all pulse");
    @(negedge clk); obs(4, 0, "R9 flush_all one cycle");
    wr(8'h0C, 32'h2);
    obs(4, 0, "R9 bit0 clear no pulse");
    wr(8'h10, 32'hABCD_E123);
    obs(5, 1, "R9 entry pulse"); obs(6, 32'hABCDE, "R9 entry page");
    @(negedge clk); obs(5, 0, "R9 entry one cycle");
    wr(8'h10, 32'h1234_5000);
    obs(5, 0, "R9 entry bit0 clear");

    // R10 config bank
    wr(8'h04, 32'h1000_1001); rd(8'h04, 32'h1000_1001, "R10 cfg");
    wr(8'h14, 32'h8000_4000); rd(8'h14, 32'h8000_4000, "R10 ptbase");
    obs(7, 32'h8000_4000, "R10 pt_base port");
    wr(8'h4C, 32'h11); wr(8'h50, 32'h22); wr(8'h54, 32'h33); wr(8'h58, 32'h44);
    rd(8'h4C, 32'h11, "R10 slot0"); rd(8'h50, 32'h22, "R10 slot1");
    rd(8'h54, 32'h33, "R10 slot2"); rd(8'h58, 32'h44, "R10 slot3");
    obs(8, 32'h22, "R10 pf_win slot1 port");

    // R11 version
    rd(8'h34, 32'h3000_0000, "R11 version");

    // R12 unmapped and read-only
    wr(8'h20, 32'hFFFF_FFFF); rd(8'h20, 0, "R12 unmapped");
    wr(8'h5C, 32'hFFFF_FFFF); rd(8'h5C, 0, "R12 past last slot");
    wr(8'h30, 32'h0); rd(8'h30, 32'h3333_0000, "R12 capture read-only");
    wr(8'h34, 32'h0); rd(8'h34, 32'h3000_0000, "R12 version read-only");
    wr(8'h18, 32'h0); rd(8'h18, 32'h08, "R12 status read-only");
    rd(8'h04, 32'h1000_1001, "R12 cfg untouched");

    @(negedge clk); #1;
    if (q.size() != 0) begin
      failures++;
      $display("FAIL scoreboard actual=%0d expected=0 pending", q.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule